// File: doc/BRIEF.md
# Transmit Capture-and-Replay Buffer

This block takes one stream transfer from an AXI4-Stream input and stores it in on-chip storage. The storage holds a power-of-two number of words. The block then plays the stored transfer back on an AXI4-Stream output. Software arms a capture with a start pulse. After arming, the controller spends one cycle in a set-up phase, in which it fixes the capture limit from the requested length. It then accepts input beats until the input's tlast arrives. Replay either begins at once or waits for an external sync trigger. In cyclic mode the replay repeats the stored beats until software aborts. Otherwise it stops after one pass.

A separate pass-through route takes over both stream ports when bypass is selected. It is a small FIFO that carries input beats straight to the output and runs whether or not the controller is busy. Two sticky status flags report problems: an input beat that found no room (overflow), and a cycle in which the output was ready but replay had no data (underflow). Software reads the length actually captured, in beats.

Top module: `txbuf_offload`

## Requirements
- R1: The storage holds exactly 2**MEM_AW words. `stat_len` never exceeds 2**MEM_AW.
- R2: `cfg_len_units` requests the length in 64-byte units, so the limit in beats is units*512/DATA_W. A value of 0 selects the whole storage. A request larger than the storage is clamped to the whole storage. The limit is sampled in the set-up phase.
- R3: A `ctl_start` pulse in idle is followed by one set-up cycle in which `s_tready` is low. `s_tready` rises in the cycle after that.
- R4: During capture, `s_tready` stays high until the beat carrying `s_tlast` is accepted, even after the limit is reached. Beats beyond the limit are dropped, and `stat_len` equals the limit.
- R5: `stat_overflow` is set by every input beat accepted when the captured count already equals the limit. It stays set until a `stat_clr` pulse. A set in the same cycle as a clear wins.
- R6: After capture, replay waits while `cfg_sync_en` is 1 and `sync_in` is low. It starts at once when `cfg_sync_en` is 0. The stored beats come out in order, `m_tlast` is high on the final stored beat only, and `m_tvalid` falls after that beat in one-shot mode.
- R7: `stat_underflow` is set whenever `m_tready` is high during replay while replay data is not yet valid. It stays set until `stat_clr`. Replay with `m_tready` raised only while `m_tvalid` is high never sets it.
- R8: With `cfg_cyclic` = 1, the beat after the final stored beat is beat 0 again, without a new capture.
- R9: With `cfg_bypass` = 1, input beats reach the output through the FIFO in order, with `s_tlast` preserved. This holds in any controller phase, and `s_tready` reflects FIFO room.
- R10: The bypass FIFO is written only while `cfg_bypass` is 1. Input offered while bypass is off never appears on the output once bypass is turned on.
- R11: `ctl_abort` returns the controller to idle and clears the address counters and `stat_len`. It drops `m_tvalid` and `s_tready`.
- R12: While `m_tvalid` is high and `m_tready` is low, `m_tdata` and `m_tvalid` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bypass | input | 1 | Route input to output through the FIFO |
| cfg_cyclic | input | 1 | Repeat the replay until abort |
| cfg_sync_en | input | 1 | Hold replay until `sync_in` |
| cfg_len_units | input | LEN_W | Capture length in 64-byte units, 0 = whole storage |
| ctl_start | input | 1 | Arm a capture (idle only) |
| ctl_abort | input | 1 | Return to idle and clear counters |
| sync_in | input | 1 | Replay trigger |
| stat_clr | input | 1 | Clear both sticky flags |
| s_tdata | input | DATA_W | Input stream data |
| s_tvalid | input | 1 | Input stream valid |
| s_tlast | input | 1 | Input stream end of transfer |
| s_tready | output | 1 | Input stream ready |
| m_tdata | output | DATA_W | Output stream data |
| m_tvalid | output | 1 | Output stream valid |
| m_tlast | output | 1 | Output stream end of transfer |
| m_tready | input | 1 | Output stream ready |
| stat_overflow | output | 1 | Sticky: beat arrived with no room |
| stat_underflow | output | 1 | Sticky: output ready, replay data missing |
| stat_len | output | MEM_AW+1 | Beats captured in the last transfer |

## Verification
The hardest state to reach from the ports is a capture cut short by its limit. It needs an input transfer longer than the sampled limit, with `s_tready` still high, and then a replay that ends on the truncated beat. The bench sweeps every length code from 0 to 5 against transfers of 1, 16, 23, 64 and 70 beats. It computes the clamped limit arithmetically, so both short and oversized transfers occur under every code, and each replay is checked beat by beat under a rotating backpressure pattern. Bypass is also run while a capture sits waiting for its sync trigger, which shows that the pass-through route never depends on the controller.

// File: rtl/txbuf_pkg.sv
package txbuf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PREP = 3'd1,
        ST_FILL = 3'd2,
        ST_HOLD = 3'd3,
        ST_PLAY = 3'd4
    } phase_e;

    // beats per 64-byte unit is 512 / data width; return its log2
    function automatic int unsigned unit_shift(int unsigned data_w);
        return $clog2(512 / data_w);
    endfunction

endpackage

// File: rtl/txbuf_ram.sv
module txbuf_ram #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [WORDS];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        if (re) rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/txbuf_bypass_fifo.sv
module txbuf_bypass_fifo #(
    parameter int WIDTH = 33,
    parameter int AW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty,
    output logic [AW:0]      level
);
    localparam int SLOTS = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [WIDTH-1:0] slot_q [SLOTS];

    always_comb begin
        d = q;
        if (push) d.wp = q.wp + 1'b1;
        if (pop)  d.rp = q.rp + 1'b1;
        if (push && !pop) d.cnt = q.cnt + 1'b1;
        else if (pop && !push) d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push) slot_q[q.wp] <= din;
    end

    assign dout  = slot_q[q.rp];
    assign full  = (q.cnt == (AW+1)'(SLOTS));
    assign empty = (q.cnt == '0);
    assign level = q.cnt;
endmodule

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
    import txbuf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MEM_AW = 6,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              cyclic,
    input  logic              sync_en,
    input  logic              sync_in,
    input  logic              clr,
    input  logic [LEN_W-1:0]  len_units,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              out_last,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_waddr,
    output logic              mem_re,
    output logic [MEM_AW-1:0] mem_raddr,
    output logic              ovf,
    output logic              unf,
    output logic [MEM_AW:0]   cap_len
);
    localparam int DEPTH  = 1 << MEM_AW;
    localparam int CNT_W  = MEM_AW + 1;
    localparam int SH     = unit_shift(DATA_W);
    localparam int WIDE_W = LEN_W + SH + 1;

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  lim;
        logic [CNT_W-1:0]  wcnt;
        logic [CNT_W-1:0]  len;
        logic [MEM_AW-1:0] rptr;
        logic              drained;
        logic              ov;
        logic              ol;
        logic              ovf;
        logic              unf;
    } ctrl_st_t;

    ctrl_st_t q, d;

    logic [WIDE_W-1:0] wide_req;
    logic [CNT_W-1:0]  req_lim;
    logic              take;
    logic              room;
    logic              issue;
    logic              at_last;

    assign wide_req = WIDE_W'(len_units) << SH;
    assign req_lim  = ((len_units == '0) || (wide_req >= WIDE_W'(DEPTH)))
                      ? CNT_W'(DEPTH) : CNT_W'(wide_req);
    assign in_ready = (q.ph == ST_FILL);
    assign take     = in_ready && in_valid;
    assign room     = (q.wcnt < q.lim);
    assign at_last  = ({1'b0, q.rptr} == (q.len - 1'b1));
    assign issue    = (q.ph == ST_PLAY) && !q.drained && (!q.ov || out_ready);

    always_comb begin
        d = q;
        if (clr) begin
            d.ovf = 1'b0;
            d.unf = 1'b0;
        end
        unique case (q.ph)
            ST_IDLE: begin
                if (start) d.ph = ST_PREP;
            end
            ST_PREP: begin
                d.lim  = req_lim;
                d.wcnt = '0;
                d.len  = '0;
                d.ph   = ST_FILL;
            end
            ST_FILL: begin
                if (take) begin
                    if (room) d.wcnt = q.wcnt + 1'b1;
                    else      d.ovf  = 1'b1;
                    if (in_last) begin
                        d.len = room ? (q.wcnt + 1'b1) : q.wcnt;
                        d.ph  = ST_HOLD;
                    end
                end
            end
            ST_HOLD: begin
                if (!sync_en || sync_in) begin
                    d.ph      = ST_PLAY;
                    d.rptr    = '0;
                    d.drained = 1'b0;
                end
            end
            ST_PLAY: begin
                if (out_ready && !q.ov) d.unf = 1'b1;
                if (out_ready && q.ov) begin
                    d.ov = 1'b0;
                    if (q.drained) d.ph = ST_IDLE;
                end
                if (issue) begin
                    d.ov = 1'b1;
                    d.ol = at_last;
                    if (at_last) begin
                        d.rptr    = '0;
                        d.drained = !cyclic;
                    end else begin
                        d.rptr = q.rptr + 1'b1;
                    end
                end
            end
            default: d.ph = ST_IDLE;
        endcase
        if (abort) begin
            d.ph      = ST_IDLE;
            d.lim     = '0;
            d.wcnt    = '0;
            d.len     = '0;
            d.rptr    = '0;
            d.drained = 1'b0;
            d.ov      = 1'b0;
            d.ol      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.ph <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign mem_we    = take && room;
    assign mem_waddr = q.wcnt[MEM_AW-1:0];
    assign mem_re    = issue;
    assign mem_raddr = q.rptr;
    assign out_valid = q.ov;
    assign out_last  = q.ov && q.ol;
    assign ovf       = q.ovf;
    assign unf       = q.unf;
    assign cap_len   = q.len;
endmodule

// File: rtl/txbuf_offload.sv
module txbuf_offload
    import txbuf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MEM_AW = 6,
    parameter int LEN_W  = 8,
    parameter int BYP_AW = 2,
    parameter bit BYP_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bypass,
    input  logic              cfg_cyclic,
    input  logic              cfg_sync_en,
    input  logic [LEN_W-1:0]  cfg_len_units,
    input  logic              ctl_start,
    input  logic              ctl_abort,
    input  logic              sync_in,
    input  logic              stat_clr,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    output logic              m_tlast,
    input  logic              m_tready,
    output logic              stat_overflow,
    output logic              stat_underflow,
    output logic [MEM_AW:0]   stat_len
);
    localparam int FIFO_W = DATA_W + 1;

    logic              cap_valid, cap_ready;
    logic              rp_ready, rp_valid, rp_last;
    logic              mem_we, mem_re;
    logic [MEM_AW-1:0] mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_rdata;
    logic              byp_push, byp_pop, byp_full, byp_empty;
    logic [FIFO_W-1:0] byp_dout;
    logic [BYP_AW:0]   byp_level;

    assign cap_valid = s_tvalid && !cfg_bypass;
    assign rp_ready  = m_tready && !cfg_bypass;

    txbuf_ctrl #(
        .DATA_W (DATA_W),
        .MEM_AW (MEM_AW),
        .LEN_W  (LEN_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (ctl_start),
        .abort     (ctl_abort),
        .cyclic    (cfg_cyclic),
        .sync_en   (cfg_sync_en),
        .sync_in   (sync_in),
        .clr       (stat_clr),
        .len_units (cfg_len_units),
        .in_valid  (cap_valid),
        .in_last   (s_tlast),
        .in_ready  (cap_ready),
        .out_ready (rp_ready),
        .out_valid (rp_valid),
        .out_last  (rp_last),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_re    (mem_re),
        .mem_raddr (mem_raddr),
        .ovf       (stat_overflow),
        .unf       (stat_underflow),
        .cap_len   (stat_len)
    );

    txbuf_ram #(
        .DATA_W (DATA_W),
        .ADDR_W (MEM_AW)
    ) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (s_tdata),
        .re    (mem_re),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    generate
        if (BYP_EN) begin : g_byp
            assign byp_push = cfg_bypass && s_tvalid && !byp_full;
            assign byp_pop  = cfg_bypass && m_tready && !byp_empty;
            txbuf_bypass_fifo #(
                .WIDTH (FIFO_W),
                .AW    (BYP_AW)
            ) u_byp (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (byp_push),
                .din   ({s_tlast, s_tdata}),
                .pop   (byp_pop),
                .dout  (byp_dout),
                .full  (byp_full),
                .empty (byp_empty),
                .level (byp_level)
            );
        end else begin : g_nobyp
            assign byp_push  = 1'b0;
            assign byp_pop   = 1'b0;
            assign byp_full  = 1'b1;
            assign byp_empty = 1'b1;
            assign byp_dout  = '0;
            assign byp_level = '0;
        end
    endgenerate

    always_comb begin
        if (cfg_bypass) begin
            s_tready = !byp_full;
            m_tvalid = !byp_empty;
            m_tdata  = byp_dout[DATA_W-1:0];
            m_tlast  = !byp_empty && byp_dout[DATA_W];
        end else begin
            s_tready = cap_ready;
            m_tvalid = rp_valid;
            m_tdata  = mem_rdata;
            m_tlast  = rp_last;
        end
    end
endmodule

// File: rtl/txbuf_offload_chk.sv
module txbuf_offload_chk #(
    parameter int DATA_W = 32,
    parameter int MEM_AW = 6,
    parameter int BYP_AW = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_bypass,
    input logic              ctl_abort,
    input logic              stat_clr,
    input logic [DATA_W-1:0] m_tdata,
    input logic              m_tvalid,
    input logic              m_tlast,
    input logic              m_tready,
    input logic              stat_overflow,
    input logic              stat_underflow,
    input logic [MEM_AW:0]   stat_len,
    input logic [BYP_AW:0]   byp_level
);
    localparam int DEPTH = 1 << MEM_AW;

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        stat_len <= (MEM_AW+1)'(DEPTH)); // R1

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stat_overflow && !stat_clr |=> stat_overflow); // R5

    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stat_underflow && !stat_clr |=> stat_underflow); // R7

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        m_tlast |-> m_tvalid); // R6

    AST_NO_BYPASS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_bypass |=> byp_level <= $past(byp_level)); // R10

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready && !ctl_abort |=>
        (cfg_bypass != $past(cfg_bypass)) || (m_tvalid && $stable(m_tdata))); // R12
endmodule

bind txbuf_offload txbuf_offload_chk #(
    .DATA_W (DATA_W),
    .MEM_AW (MEM_AW),
    .BYP_AW (BYP_AW)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_bypass     (cfg_bypass),
    .ctl_abort      (ctl_abort),
    .stat_clr       (stat_clr),
    .m_tdata        (m_tdata),
    .m_tvalid       (m_tvalid),
    .m_tlast        (m_tlast),
    .m_tready       (m_tready),
    .stat_overflow  (stat_overflow),
    .stat_underflow (stat_underflow),
    .stat_len       (stat_len),
    .byp_level      (byp_level)
);

// File: tb/txbuf_offload_tb.sv
`timescale 1ns/1ps
module txbuf_offload_tb;
    localparam int DATA_W = 32;
    localparam int MEM_AW = 6;
    localparam int LEN_W  = 8;
    localparam int DEPTH  = 1 << MEM_AW;
    localparam int BPU    = 512 / DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_bypass = 0, cfg_cyclic = 0, cfg_sync_en = 0;
    logic [LEN_W-1:0]  cfg_len_units = '0;
    logic              ctl_start = 0, ctl_abort = 0, sync_in = 0, stat_clr = 0;
    logic [DATA_W-1:0] s_tdata = '0;
    logic              s_tvalid = 0, s_tlast = 0;
    logic              s_tready;
    logic [DATA_W-1:0] m_tdata;
    logic              m_tvalid, m_tlast;
    logic              m_tready = 0;
    logic              stat_overflow, stat_underflow;
    logic [MEM_AW:0]   stat_len;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    txbuf_offload #(.DATA_W(DATA_W), .MEM_AW(MEM_AW), .LEN_W(LEN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_bypass(cfg_bypass), .cfg_cyclic(cfg_cyclic),
        .cfg_sync_en(cfg_sync_en), .cfg_len_units(cfg_len_units), .ctl_start(ctl_start),
        .ctl_abort(ctl_abort), .sync_in(sync_in), .stat_clr(stat_clr),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast), .s_tready(s_tready),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready),
        .stat_overflow(stat_overflow), .stat_underflow(stat_underflow), .stat_len(stat_len)
    );

    task automatic chk_eq(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int limit_of(int units);
        int l;
        l = units * BPU;
        if (units == 0 || l > DEPTH) l = DEPTH;
        return l;
    endfunction

    task automatic pulse_clr();
        @(negedge clk); stat_clr = 1;
        @(negedge clk); stat_clr = 0;
    endtask

    // returns the number of cycles s_tready was low after the first beat
    task automatic send_beats(int n, int base, bit with_last, output int stalls);
        stalls = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_tvalid = 1; s_tdata = DATA_W'(base + i); s_tlast = with_last && (i == n - 1);
            while (!s_tready) begin
                if (i > 0) stalls++;
                @(negedge clk);
            end
        end
        @(negedge clk);
        s_tvalid = 0; s_tlast = 0;
    endtask

    task automatic recv_beats(string req, int cnt, int base, int len, int rot);
        int got = 0;
        int guard = 0;
        while (got < cnt && guard < 5000) begin
            @(negedge clk);
            guard++;
            m_tready = m_tvalid && (((got + guard + rot) % 3) != 0);
            if (m_tvalid && m_tready) begin
                chk_eq(req, "beat data", m_tdata, base + (got % len));
                chk_eq(req, "beat last", m_tlast, (got % len) == len - 1);
                got++;
            end
        end
        chk_eq(req, "beats received", got, cnt);
        @(negedge clk);
        m_tready = 0;
    endtask

    task automatic arm(int units, bit sync);
        @(negedge clk);
        cfg_len_units = LEN_W'(units); cfg_sync_en = sync; ctl_start = 1;
        @(negedge clk);
        ctl_start = 0;
    endtask

    initial begin
        #750000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int stalls;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_eq("R11", "reset s_tready", s_tready, 0);
        chk_eq("R11", "reset m_tvalid", m_tvalid, 0);
        chk_eq("R5", "reset overflow", stat_overflow, 0);
        chk_eq("R7", "reset underflow", stat_underflow, 0);
        chk_eq("R1", "reset length", stat_len, 0);

        // sweep: length codes against transfer sizes (R1 R2 R3 R4 R5 R6 R7 R12)
        for (int u = 0; u <= 5; u++) begin
            for (int k = 0; k < 5; k++) begin
                int n, lim, base;
                bit sync;
                n    = (k == 0) ? 1 : (k == 1) ? 16 : (k == 2) ? 23 : (k == 3) ? 64 : 70;
                lim  = limit_of(u);
                base = 1000 * (u + 1) + 100 * k;
                sync = ((u + k) % 2) == 1;
                pulse_clr();
                arm(u, sync);
                chk_eq("R3", "ready low in set-up", s_tready, 0);
                @(negedge clk);
                chk_eq("R3", "ready high after set-up", s_tready, 1);
                send_beats(n, base, 1'b1, stalls);
                chk_eq("R4", "no stall while capturing", stalls, 0);
                chk_eq("R2", "captured length", stat_len, (n < lim) ? n : lim);
                chk_eq("R5", "overflow flag", stat_overflow, n > lim);
                if (sync) begin
                    repeat (3) @(negedge clk);
                    chk_eq("R6", "held for sync", m_tvalid, 0);
                    sync_in = 1;
                    @(negedge clk);
                    sync_in = 0;
                end
                recv_beats("R6", (n < lim) ? n : lim, base, (n < lim) ? n : lim, u + k);
                chk_eq("R6", "valid low after one pass", m_tvalid, 0);
                chk_eq("R7", "no underflow when ready follows valid", stat_underflow, 0);
            end
        end

        // R5 / R7: sticky flags, set by ready-before-valid, cleared by pulse
        pulse_clr();
        m_tready = 1;
        arm(1, 1'b0);
        send_beats(20, 50, 1'b1, stalls);
        repeat (30) @(negedge clk);
        m_tready = 0;
        chk_eq("R7", "underflow set", stat_underflow, 1);
        chk_eq("R5", "overflow set and kept", stat_overflow, 1);
        pulse_clr();
        chk_eq("R7", "underflow cleared", stat_underflow, 0);
        chk_eq("R5", "overflow cleared", stat_overflow, 0);

        // R8: cyclic replay
        cfg_cyclic = 1;
        arm(1, 1'b0);
        send_beats(5, 300, 1'b1, stalls);
        recv_beats("R8", 17, 300, 5, 0);
        @(negedge clk); ctl_abort = 1;
        @(negedge clk); ctl_abort = 0;
        chk_eq("R11", "abort drops valid", m_tvalid, 0);
        chk_eq("R11", "abort clears length", stat_len, 0);
        chk_eq("R11", "abort leaves ready low", s_tready, 0);
        cfg_cyclic = 0;

        // R11: abort during capture, then a fresh capture restarts at zero
        arm(0, 1'b0);
        send_beats(3, 400, 1'b0, stalls);
        @(negedge clk); ctl_abort = 1;
        @(negedge clk); ctl_abort = 0;
        chk_eq("R11", "abort in capture ready", s_tready, 0);
        chk_eq("R11", "abort in capture length", stat_len, 0);
        arm(0, 1'b0);
        send_beats(4, 500, 1'b1, stalls);
        chk_eq("R11", "length after restart", stat_len, 4);
        recv_beats("R11", 4, 500, 4, 1);

        // R10: input captured while bypass off never leaks once bypass is on
        arm(0, 1'b1);
        send_beats(3, 600, 1'b1, stalls);
        cfg_bypass = 1;
        @(negedge clk);
        chk_eq("R10", "no stale bypass data", m_tvalid, 0);
        @(negedge clk);
        chk_eq("R10", "no stale bypass data later", m_tvalid, 0);

        // R9: bypass runs while the controller waits for its sync
        fork
            send_beats(10, 700, 1'b1, stalls);
            recv_beats("R9", 10, 700, 10, 2);
        join
        chk_eq("R9", "fifo drained", m_tvalid, 0);
        cfg_bypass = 0;
        @(negedge clk);
        chk_eq("R9", "stored length untouched", stat_len, 3);
        sync_in = 1;
        @(negedge clk);
        sync_in = 0;
        recv_beats("R9", 3, 600, 3, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule